// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the host side of a serial link to an eight-input, 14-bit successive-approximation converter. The converter takes its clock from the host. A single start request makes the block run one complete conversion frame. It pulls chip select low and generates a serial clock whose low and high phases are set by a divider. It shifts out a short command that carries the channel number, then collects the converter's MSB-first reply. The 14-bit code is presented with a one-cycle valid strobe.

Two word-width modes are supported. In the narrow mode a frame lasts 24 serial clocks. In the wide mode the converter holds its acquisition window open eight clocks longer, so the frame lasts 32 serial clocks and the reply starts eight clocks later. The sample window inside the block follows the mode that was latched at start. After each frame, chip select is held high for a programmable number of system clocks before another request is taken. This keeps the deselect time above the converter's minimum. Chip select is never released in the middle of a frame, because that would abort the conversion and power the converter down.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, and sclk_o, mosi_o, busy_o and valid_o are all 0.
- R2: sclk_o is low whenever cs_n_o is high. Inside a frame, every low phase and every high phase of sclk_o lasts exactly div_i+1 system clocks, using the div_i value captured when the start is accepted.
- R3: The first three rising sclk_o edges of a frame carry chan_i MSB first on mosi_o. All later bits of the frame are 0. mosi_o changes only while sclk_o is low.
- R4: With wide_i=0 at start, a frame has 24 rising sclk_o edges. miso_i is sampled on rising edges 9 to 22.
- R5: With wide_i=1 at start, a frame has 32 rising sclk_o edges. miso_i is sampled on rising edges 17 to 30.
- R6: data_o holds the 14 sampled bits, the first one as bit 13. The bits that arrive after those 14 are discarded. data_o changes only at the edge where valid_o rises.
- R7: cs_n_o stays low for the whole frame. It rises in the same cycle that valid_o pulses high for exactly one clock, and sclk_o is low in that cycle.
- R8: busy_o rises on the clock after a start is accepted and falls on the edge where valid_o rises.
- R9: A start_i pulse while busy_o is high has no effect. It starts no second frame and does not change the command bits, the mode or the divider of the frame in progress.
- R10: After cs_n_o rises with a gap setting of gap_i >= 1 and start_i held high, cs_n_o stays high for exactly gap_i+1 system clocks. Requests during that time are not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| chan_i | input | 3 | Channel number sent in the command |
| wide_i | input | 1 | 1 selects the 16-bit word mode, 0 the 8-bit mode |
| div_i | input | DIV_W | Serial clock half-period minus one, in system clocks |
| gap_i | input | GAP_W | Minimum deselect time after a frame |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Command data to the converter |
| busy_o | output | 1 | A frame is in progress |
| valid_o | output | 1 | One-cycle strobe: data_o is new |
| data_o | output | 14 | Last conversion code |

## Verification
Two functions can meet in one cycle: the end of a frame (chip select rises, valid pulses, busy falls) and a new request. The bench provokes this by holding start_i high across the end of a frame. It then judges the result by counting the system clocks in which chip select stays high, which must be exactly the gap setting plus one, and by checking the second frame's result. It also raises start_i mid-frame with a different channel, mode and divider. It then checks that the frame in progress keeps its command bits, its edge count and its phase lengths, and that no extra chip-select fall follows.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_GAP  = 2'd3
  } fr_state_e;

  localparam int CH_BITS      = 3;
  localparam int RES_BITS     = 14;
  localparam int CMD_BITS     = 8;
  localparam int CYC_W        = 6;
  localparam int NARROW_FRAME = 24;
  localparam int WIDE_FRAME   = 32;
  localparam int NARROW_FIRST = 9;
  localparam int WIDE_FIRST   = 17;

  // Number of serial clock cycles in one frame for the given mode.
  function automatic logic [CYC_W-1:0] frame_cycles(input logic wide);
    return wide ? CYC_W'(WIDE_FRAME) : CYC_W'(NARROW_FRAME);
  endfunction

  // Serial clock cycle whose rising edge samples the first result bit.
  function automatic logic [CYC_W-1:0] first_sample(input logic wide);
    return wide ? CYC_W'(WIDE_FIRST) : CYC_W'(NARROW_FIRST);
  endfunction

endpackage

// File: rtl/adc_sclk_timer.sv
module adc_sclk_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  // Fires on the last system clock of a serial clock phase.
  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_frame_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wide_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             tick_i,
  output logic             timer_run_o,
  output logic [DIV_W-1:0] div_q_o,
  output logic             accept_o,
  output logic             sample_o,
  output logic             advance_o,
  output logic             done_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             valid_o
);

  fr_state_e        state_q, state_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             wide_q, wide_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             cs_n_q, cs_n_d;
  logic             sclk_q, sclk_d;
  logic             valid_q, valid_d;

  logic             last_cyc;
  logic             in_window;
  logic [CYC_W-1:0] first_cyc;

  assign first_cyc   = first_sample(wide_q);
  assign last_cyc    = (cyc_q == frame_cycles(wide_q));
  assign in_window   = (cyc_q >= first_cyc) && (cyc_q < first_cyc + CYC_W'(RES_BITS));
  assign timer_run_o = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign div_q_o     = div_q;

  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign sample_o  = (state_q == ST_LOW)  && tick_i && in_window;
  assign advance_o = (state_q == ST_HIGH) && tick_i && !last_cyc;
  assign done_o    = (state_q == ST_HIGH) && tick_i && last_cyc;

  always_comb begin
    state_d = state_q;
    cyc_d   = cyc_q;
    wide_d  = wide_q;
    div_d   = div_q;
    gap_d   = gap_q;
    cs_n_d  = cs_n_q;
    sclk_d  = sclk_q;
    valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOW;
          cyc_d   = CYC_W'(1);
          wide_d  = wide_i;
          div_d   = div_i;
          cs_n_d  = 1'b0;
          sclk_d  = 1'b0;
        end
      end
      ST_LOW: begin
        if (tick_i) begin
          state_d = ST_HIGH;
          sclk_d  = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tick_i) begin
          sclk_d = 1'b0;
          if (last_cyc) begin
            state_d = ST_GAP;
            cs_n_d  = 1'b1;
            valid_d = 1'b1;
            gap_d   = gap_i;
          end else begin
            state_d = ST_LOW;
            cyc_d   = cyc_q + CYC_W'(1);
          end
        end
      end
      ST_GAP: begin
        if (gap_q <= GAP_W'(1)) state_d = ST_IDLE;
        else                    gap_d   = gap_q - GAP_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      wide_q  <= 1'b0;
      div_q   <= '0;
      gap_q   <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cyc_q   <= cyc_d;
      wide_q  <= wide_d;
      div_q   <= div_d;
      gap_q   <= gap_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      valid_q <= valid_d;
    end
  end

  assign cs_n_o  = cs_n_q;
  assign sclk_o  = sclk_q;
  assign valid_o = valid_q;
  assign busy_o  = timer_run_o;

  AST_SCLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o); // R2
  AST_CS_RISE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> valid_o); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7
  AST_BUSY_ENDS_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> valid_o); // R8
  AST_SELECT_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($past(state_q) == ST_IDLE)); // R10
  AST_CYCLE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cyc_q >= CYC_W'(1) && cyc_q <= frame_cycles(wide_q))); // R4

endmodule

// File: rtl/adc_shift_path.sv
module adc_shift_path
  import adc_frame_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH_BITS-1:0]  chan_i,
  input  logic                accept_i,
  input  logic                advance_i,
  input  logic                sample_i,
  input  logic                done_i,
  input  logic                miso_i,
  output logic                mosi_o,
  output logic [RES_BITS-1:0] data_o
);

  localparam int PAD_BITS = CMD_BITS - CH_BITS;

  logic [CMD_BITS-1:0] cmd_q, cmd_d;
  logic [RES_BITS-1:0] cap_q, cap_d;
  logic [RES_BITS-1:0] data_q, data_d;

  always_comb begin
    cmd_d = cmd_q;
    if (accept_i)       cmd_d = {chan_i, {PAD_BITS{1'b0}}};
    else if (done_i)    cmd_d = '0;
    else if (advance_i) cmd_d = {cmd_q[CMD_BITS-2:0], 1'b0};
  end

  always_comb begin
    cap_d = cap_q;
    if (accept_i)      cap_d = '0;
    else if (sample_i) cap_d = {cap_q[RES_BITS-2:0], miso_i};
  end

  always_comb begin
    data_d = data_q;
    if (done_i) data_d = cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      cap_q  <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      cap_q  <= cap_d;
      data_q <= data_d;
    end
  end

  assign mosi_o = cmd_q[CMD_BITS-1];
  assign data_o = data_q;

  AST_MOSI_LOW_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !mosi_o); // R3
  AST_DATA_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(data_o)); // R6
  AST_NO_SAMPLE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |-> !sample_i && !done_i); // R6

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CH_BITS-1:0]  chan_i,
  input  logic                wide_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [GAP_W-1:0]    gap_i,
  input  logic                miso_i,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                mosi_o,
  output logic                busy_o,
  output logic                valid_o,
  output logic [RES_BITS-1:0] data_o
);

  // Reset asserts at once and is released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             tick;
  logic             timer_run;
  logic [DIV_W-1:0] div_q;
  logic             accept;
  logic             sample;
  logic             advance;
  logic             done;

  adc_sclk_timer #(.DIV_W(DIV_W)) timer_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (timer_run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  adc_frame_seq #(.DIV_W(DIV_W), .GAP_W(GAP_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .wide_i      (wide_i),
    .div_i       (div_i),
    .gap_i       (gap_i),
    .tick_i      (tick),
    .timer_run_o (timer_run),
    .div_q_o     (div_q),
    .accept_o    (accept),
    .sample_o    (sample),
    .advance_o   (advance),
    .done_o      (done),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .busy_o      (busy_o),
    .valid_o     (valid_o)
  );

  adc_shift_path path_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .chan_i    (chan_i),
    .accept_i  (accept),
    .advance_i (advance),
    .sample_i  (sample),
    .done_i    (done),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .data_o    (data_o)
  );

endmodule

// File: tb/adc_frame_ctrl_tb_top.sv
module adc_frame_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  chan_i;
  logic        wide_i;
  logic [7:0]  div_i;
  logic [7:0]  gap_i;
  logic        miso_i;
  logic        cs_n_o, sclk_o, mosi_o, busy_o, valid_o;
  logic [13:0] data_o;

  int n_chk, n_bad, n_clk;

  // converter model state
  int          m_rise, m_first, m_falls, idx;
  logic [15:0] m_word;
  logic [31:0] m_cmd;
  // phase monitor state
  int   run_len, hmin, hmax, lmin, lmax, mosi_moves;
  logic prev_s, prev_cs, prev_mosi;

  adc_frame_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .wide_i(wide_i), .div_i(div_i), .gap_i(gap_i), .miso_i(miso_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .busy_o(busy_o),
    .valid_o(valid_o), .data_o(data_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    n_clk++;
    if (n_clk > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_clk, 150000);
      finish_run();
    end
  end

  // converter model: latches command on rising, drives reply after falling
  always @(negedge cs_n_o) begin
    m_rise = 0; m_cmd = '0; miso_i = 1'b0; m_falls++;
  end
  always @(posedge sclk_o) if (!cs_n_o) begin
    m_rise++;
    m_cmd = {m_cmd[30:0], mosi_o};
  end
  always @(negedge sclk_o) if (!cs_n_o) begin
    idx = m_rise - (m_first - 1);
    if (idx >= 0 && idx < 16) miso_i = m_word[15-idx];
    else                      miso_i = 1'b0;
  end

  task automatic rec(input logic lvl, input int len);
    if (lvl) begin
      if (len < hmin) hmin = len;
      if (len > hmax) hmax = len;
    end else begin
      if (len < lmin) lmin = len;
      if (len > lmax) lmax = len;
    end
  endtask

  always @(negedge clk) begin
    if (!cs_n_o) begin
      if (prev_cs) run_len = 1;
      else if (sclk_o == prev_s) run_len++;
      else begin rec(prev_s, run_len); run_len = 1; end
      if (sclk_o && prev_s && !prev_cs && mosi_o != prev_mosi) mosi_moves++;
    end else if (!prev_cs) begin
      rec(prev_s, run_len);
    end
    prev_s = sclk_o; prev_cs = cs_n_o; prev_mosi = mosi_o;
  end

  task automatic run_frame(input logic [2:0] ch, input bit wd, input int dv,
                           input logic [13:0] code, input bit poke);
    int guard, exp_n, falls0;
    exp_n   = wd ? 32 : 24;
    m_first = wd ? 17 : 9;
    m_word  = {code, 2'b11};
    hmin = 1000; hmax = 0; lmin = 1000; lmax = 0;
    @(negedge clk);
    chan_i = ch; wide_i = wd; div_i = 8'(dv); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; chan_i = ~ch; wide_i = ~wd; div_i = 8'(dv + 2);
    falls0 = m_falls;
    chk(busy_o == 1'b1, "R8 busy after accept", busy_o, 1);
    guard = 0;
    while (!valid_o && guard < 5000) begin
      start_i = (poke && m_rise == 5) ? 1'b1 : 1'b0; // R9 mid-frame request
      @(negedge clk);
      guard++;
    end
    start_i = 1'b0;
    chk(valid_o == 1'b1, "R7 valid seen", valid_o, 1);
    chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R7 cs high with valid", cs_n_o, 1);
    chk(busy_o == 1'b0, "R8 busy low at valid", busy_o, 0);
    chk(data_o == code, "R6 result code", data_o, code);
    if (wd) chk(m_rise == exp_n, "R5 wide edge count", m_rise, exp_n);
    else    chk(m_rise == exp_n, "R4 narrow edge count", m_rise, exp_n);
    chk(m_cmd[exp_n-1 -: 3] == ch, "R3 channel bits", m_cmd[exp_n-1 -: 3], ch);
    chk((m_cmd & ((32'd1 << (exp_n-3)) - 1)) == 0, "R3 trailing zeros",
        m_cmd & ((32'd1 << (exp_n-3)) - 1), 0);
    chk(hmin == dv+1 && hmax == dv+1, "R2 high phase", hmax, dv+1);
    chk(lmin == dv+1 && lmax == dv+1, "R2 low phase", lmax, dv+1);
    @(negedge clk);
    chk(valid_o == 1'b0, "R7 valid one cycle", valid_o, 0);
    repeat (20) @(negedge clk);
    chk(m_falls == falls0, "R9 no extra frame", m_falls, falls0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; n_clk = 0;
    m_rise = 0; m_first = 9; m_falls = 0; m_word = '0; m_cmd = '0; idx = 0;
    run_len = 0; hmin = 1000; hmax = 0; lmin = 1000; lmax = 0; mosi_moves = 0;
    prev_s = 1'b0; prev_cs = 1'b1; prev_mosi = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; chan_i = '0; wide_i = 1'b0;
    div_i = '0; gap_i = 8'd2; miso_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1 cs_n reset", cs_n_o, 1);
    chk(sclk_o == 1'b0 && mosi_o == 1'b0, "R1 sclk/mosi reset", sclk_o, 0);
    chk(busy_o == 1'b0 && valid_o == 1'b0, "R1 busy/valid reset", busy_o, 0);

    for (int ch = 0; ch < 8; ch++)
      for (int wd = 0; wd < 2; wd++)
        for (int k = 0; k < 3; k++) begin
          int dv;
          dv = (k == 0) ? 0 : (k == 1) ? 1 : 3;
          run_frame(3'(ch), wd[0], dv,
                    14'((ch * 1237 + wd * 4111 + dv * 613 + 5) & 16'h3fff),
                    (ch % 3) == 0);
        end
    run_frame(3'd7, 1'b1, 2, 14'h3fff, 1'b0); // R6 all ones
    run_frame(3'd0, 1'b0, 2, 14'h0000, 1'b0); // R6 all zeros
    chk(mosi_moves == 0, "R3 mosi stable while sclk high", mosi_moves, 0);

    // R10: start held across frame end; deselect time and second frame
    begin
      int guard, hi;
      gap_i = 8'd4; m_first = 9; m_word = {14'h1a5c, 2'b11};
      @(negedge clk);
      chan_i = 3'd5; wide_i = 1'b0; div_i = 8'd0; start_i = 1'b1;
      guard = 0;
      while (!valid_o && guard < 5000) begin @(negedge clk); guard++; end
      hi = 0;
      while (cs_n_o && hi < 100) begin hi++; @(negedge clk); end
      start_i = 1'b0;
      chk(hi == 5, "R10 deselect clocks", hi, 5);
      guard = 0;
      while (!valid_o && guard < 5000) begin @(negedge clk); guard++; end
      chk(data_o == 14'h1a5c, "R10 second frame result", data_o, 14'h1a5c);
      chk(m_cmd[23 -: 3] == 3'd5, "R10 second frame channel", m_cmd[23 -: 3], 5);
      repeat (20) @(negedge clk);
    end
    finish_run();
  end

endmodule